// File: doc/BRIEF.md
# USB Endpoint STALL Handshake Manager

This block keeps, for each of a set of USB device endpoints, a stall-request bit and decides for every token reported by the protocol engine whether that token is answered with a STALL handshake or handled normally. Software raises or drops the stall request through per-endpoint set and clear strobes. Once raised, the request stays in force across any number of transactions. Every token that reaches the endpoint while it is in force is refused. The flags that would normally report received data stay low for a refused token.

On a control endpoint a fresh SETUP packet always gets through and cancels the stall request. On other endpoint types only software can cancel it. Every STALL the block orders sets a per-endpoint stalled flag. The flag stays set until software acknowledges it, and it drives the endpoint interrupt when enabled. The decision for a token is registered and appears one clock after the token, together with the endpoint number and token kind it belongs to.

Top module: `usb_ep_stall_ctrl`

## Requirements
- R1: After reset, all stall requests, stalled flags, endpoint interrupts and both response pulses (`hs_stall_o`, `rx_accept_o`) are 0.
- R2: A 1 on `stall_set_i[n]` makes `stall_req_o[n]` read 1 from the next clock edge. Token codes on `tok_kind_i` are 2'b00 no token, 2'b01 SETUP, 2'b10 IN and 2'b11 OUT.
- R3: While `stall_req_o[n]` is 1, each IN or OUT token on endpoint n produces a one-cycle `hs_stall_o` pulse with `rx_accept_o` low, in the cycle after the token. The request stays set afterwards.
- R4: A token on an endpoint whose stall request is 0 produces a one-cycle `rx_accept_o` pulse with `hs_stall_o` low, in the cycle after the token.
- R5: A SETUP token on an endpoint with `ep_is_ctrl_i[n]` = 1 is accepted even while stalled, and it clears `stall_req_o[n]`.
- R6: A SETUP token on an endpoint with `ep_is_ctrl_i[n]` = 0 is stalled while the request is set and leaves the request set.
- R7: A 1 on `stall_clr_i[n]` clears `stall_req_o[n]` on any endpoint type.
- R8: A set strobe wins over a clear strobe, and over a SETUP-driven clear, that arrive in the same cycle.
- R9: Each ordered STALL sets `stalled_o[n]`, which holds until a 1 on `stalled_ack_i[n]`. A STALL in the same cycle as the acknowledge leaves the flag set.
- R10: `ep_irq_o[n]` is 1 exactly when `stalled_o[n]` and `stalled_ien_i[n]` are both 1.
- R11: `resp_ep_o` and `resp_kind_o` give the endpoint and kind of the token that the response pulse belongs to. A token on one endpoint changes no other endpoint's stall request or flag.
- R12: A `tok_kind_i` of 2'b00 produces no response pulse and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_kind_i | input | 2 | Token kind from the protocol engine (00 none, 01 SETUP, 10 IN, 11 OUT) |
| tok_ep_i | input | EP_W | Endpoint addressed by the token |
| ep_is_ctrl_i | input | NUM_EP | Endpoint is of control type |
| stall_set_i | input | NUM_EP | Software strobe raising the stall request |
| stall_clr_i | input | NUM_EP | Software strobe dropping the stall request |
| stalled_ack_i | input | NUM_EP | Write-one-to-clear strobe for the stalled flag |
| stalled_ien_i | input | NUM_EP | Stalled flag interrupt enable |
| stall_req_o | output | NUM_EP | Current stall request per endpoint |
| hs_stall_o | output | 1 | Pulse: answer the last token with STALL |
| rx_accept_o | output | 1 | Pulse: last token handled normally, data flags may be raised |
| resp_kind_o | output | 2 | Kind of the token the pulse belongs to |
| resp_ep_o | output | EP_W | Endpoint of the token the pulse belongs to |
| stalled_o | output | NUM_EP | Stalled flag per endpoint |
| ep_irq_o | output | NUM_EP | Endpoint interrupt |

## Verification
Tokens of each kind are sent to endpoints with the stall request both clear and set, so that a refused token can be told apart from a normal one. A SETUP is sent to a stalled control endpoint and to a stalled bulk endpoint, which shows whether the automatic clear depends on the endpoint type. Strobes that collide in one cycle (set with clear, set with a SETUP clear, STALL with acknowledge) show which side wins. Tokens on neighbouring endpoints and the no-token code show that state does not leak from one endpoint to another and that idle cycles are quiet.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'b00,
    TOK_SETUP = 2'b01,
    TOK_IN    = 2'b10,
    TOK_OUT   = 2'b11
  } tok_kind_e;

endpackage

// File: rtl/ep_stall_state.sv
module ep_stall_state (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic is_ctrl_i,
  input  logic setup_hit_i,
  output logic stall_o
);

  logic stall_q;
  logic stall_d;
  logic auto_clr;
  logic upd_en;

  assign auto_clr = setup_hit_i & is_ctrl_i;
  assign upd_en   = set_i | clr_i | auto_clr;

  always_comb begin
    stall_d = stall_q;
    if (set_i) begin
      stall_d = 1'b1;
    end else if (clr_i || auto_clr) begin
      stall_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
    end else if (upd_en) begin
      stall_q <= stall_d;
    end
  end

  assign stall_o = stall_q;

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> stall_q); // R8
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !stall_q); // R7
  AST_CTRL_SETUP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_hit_i && is_ctrl_i && !set_i) |=> !stall_q); // R5
  AST_BULK_SETUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && setup_hit_i && !is_ctrl_i && !clr_i) |=> stall_q); // R6

endmodule

// File: rtl/ep_stall_flag.sv
module ep_stall_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_sent_i,
  input  logic ack_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  assign flag_en = stall_sent_i | ack_i;

  always_comb begin
    flag_d = flag_q;
    if (stall_sent_i) begin
      flag_d = 1'b1;
    end else if (ack_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;

  AST_FLAG_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent_i |=> flag_q); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_i) |=> flag_q); // R9
  AST_FLAG_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !stall_sent_i) |=> !flag_q); // R9

endmodule

// File: rtl/stall_resp_reg.sv
module stall_resp_reg
  import usb_stall_pkg::*;
#(
  parameter int EP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tok_kind_e       kind_i,
  input  logic [EP_W-1:0] ep_i,
  input  logic            stall_sel_i,
  input  logic            ctrl_sel_i,
  output logic            stall_now_o,
  output logic            hs_stall_o,
  output logic            accept_o,
  output tok_kind_e       kind_o,
  output logic [EP_W-1:0] ep_o
);

  logic            tok_present;
  logic            setup_pass;
  logic            stall_now;
  logic            accept_now;
  logic            hs_q;
  logic            acc_q;
  tok_kind_e       kind_q;
  logic [EP_W-1:0] ep_q;

  assign tok_present = (kind_i != TOK_NONE);
  assign setup_pass  = (kind_i == TOK_SETUP) & ctrl_sel_i;
  assign stall_now   = tok_present & stall_sel_i & ~setup_pass;
  assign accept_now  = tok_present & ~stall_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      hs_q  <= stall_now;
      acc_q <= accept_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= TOK_NONE;
      ep_q   <= '0;
    end else if (tok_present) begin
      kind_q <= kind_i;
      ep_q   <= ep_i;
    end
  end

  assign stall_now_o = stall_now;
  assign hs_stall_o  = hs_q;
  assign accept_o    = acc_q;
  assign kind_o      = kind_q;
  assign ep_o        = ep_q;

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && acc_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == TOK_NONE) |=> (!hs_q && !acc_q)); // R12
  AST_CTRL_SETUP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_i == TOK_SETUP) && ctrl_sel_i) |=> (acc_q && !hs_q)); // R5
  AST_STALLED_DATA_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_sel_i && (kind_i == TOK_IN || kind_i == TOK_OUT)) |=> (hs_q && !acc_q)); // R3

endmodule

// File: rtl/usb_ep_stall_ctrl.sv
module usb_ep_stall_ctrl
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tok_kind_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [NUM_EP-1:0] ep_is_ctrl_i,
  input  logic [NUM_EP-1:0] stall_set_i,
  input  logic [NUM_EP-1:0] stall_clr_i,
  input  logic [NUM_EP-1:0] stalled_ack_i,
  input  logic [NUM_EP-1:0] stalled_ien_i,
  output logic [NUM_EP-1:0] stall_req_o,
  output logic              hs_stall_o,
  output logic              rx_accept_o,
  output logic [1:0]        resp_kind_o,
  output logic [EP_W-1:0]   resp_ep_o,
  output logic [NUM_EP-1:0] stalled_o,
  output logic [NUM_EP-1:0] ep_irq_o
);

  tok_kind_e         kind_in;
  tok_kind_e         kind_out;
  logic [NUM_EP-1:0] ep_hit;
  logic [NUM_EP-1:0] stall_vec;
  logic [NUM_EP-1:0] flag_vec;
  logic              stall_sel;
  logic              ctrl_sel;
  logic              stall_now;
  logic              ep_in_range;

  assign kind_in     = tok_kind_e'(tok_kind_i);
  assign ep_in_range = (int'(tok_ep_i) < NUM_EP);

  always_comb begin
    stall_sel = 1'b0;
    ctrl_sel  = 1'b0;
    for (int k = 0; k < NUM_EP; k++) begin
      if (ep_hit[k]) begin
        stall_sel = stall_vec[k];
        ctrl_sel  = ep_is_ctrl_i[k];
      end
    end
  end

  stall_resp_reg #(
    .EP_W (EP_W)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind_i      (ep_in_range ? kind_in : TOK_NONE),
    .ep_i        (tok_ep_i),
    .stall_sel_i (stall_sel),
    .ctrl_sel_i  (ctrl_sel),
    .stall_now_o (stall_now),
    .hs_stall_o  (hs_stall_o),
    .accept_o    (rx_accept_o),
    .kind_o      (kind_out),
    .ep_o        (resp_ep_o)
  );

  assign resp_kind_o = kind_out;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic setup_hit;
    logic stall_sent;

    assign ep_hit[g]  = (kind_in != TOK_NONE) && (int'(tok_ep_i) == g);
    assign setup_hit  = ep_hit[g] && (kind_in == TOK_SETUP);
    assign stall_sent = ep_hit[g] && stall_now;

    ep_stall_state u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (stall_set_i[g]),
      .clr_i       (stall_clr_i[g]),
      .is_ctrl_i   (ep_is_ctrl_i[g]),
      .setup_hit_i (setup_hit),
      .stall_o     (stall_vec[g])
    );

    ep_stall_flag u_flag (
      .clk          (clk),
      .rst_n        (rst_n),
      .stall_sent_i (stall_sent),
      .ack_i        (stalled_ack_i[g]),
      .ien_i        (stalled_ien_i[g]),
      .flag_o       (flag_vec[g]),
      .irq_o        (ep_irq_o[g])
    );

    AST_OTHER_EP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ep_hit[g] && !stall_set_i[g] && !stall_clr_i[g]) |=> $stable(stall_vec[g])); // R11
  end

  assign stall_req_o = stall_vec;
  assign stalled_o   = flag_vec;

  AST_STALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stall_o |-> stalled_o[resp_ep_o]); // R9

endmodule

// File: tb/usb_ep_stall_ctrl_tb_top.sv
module usb_ep_stall_ctrl_tb_top;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam logic [1:0] K_NONE = 2'b00, K_SETUP = 2'b01, K_IN = 2'b10, K_OUT = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        tok_kind;
  logic [EP_W-1:0]   tok_ep;
  logic [NUM_EP-1:0] is_ctrl, s_set, s_clr, f_ack, f_ien;
  logic [NUM_EP-1:0] stall_req, stalled, irq;
  logic              hs_stall, rx_acc;
  logic [1:0]        r_kind;
  logic [EP_W-1:0]   r_ep;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  usb_ep_stall_ctrl #(.NUM_EP(NUM_EP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_kind_i(tok_kind), .tok_ep_i(tok_ep),
    .ep_is_ctrl_i(is_ctrl), .stall_set_i(s_set), .stall_clr_i(s_clr),
    .stalled_ack_i(f_ack), .stalled_ien_i(f_ien), .stall_req_o(stall_req),
    .hs_stall_o(hs_stall), .rx_accept_o(rx_acc), .resp_kind_o(r_kind),
    .resp_ep_o(r_ep), .stalled_o(stalled), .ep_irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample after the following edge.
  task automatic cyc(logic [1:0] k, logic [EP_W-1:0] e, logic [3:0] st, logic [3:0] cl, logic [3:0] ak);
    tok_kind = k; tok_ep = e; s_set = st; s_clr = cl; f_ack = ak;
    @(negedge clk);
    tok_kind = K_NONE; s_set = '0; s_clr = '0; f_ack = '0;
  endtask

  task automatic t_reset;
    chk("R1 stall_req", stall_req, 0);
    chk("R1 stalled", stalled, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pulses", {hs_stall, rx_acc}, 0);
  endtask

  task automatic t_normal;
    cyc(K_IN, 2'd1, 0, 0, 0);
    chk("R4 accept IN", {hs_stall, rx_acc}, 2'b01);
    chk("R11 ep", r_ep, 1);
    chk("R11 kind", r_kind, K_IN);
    cyc(K_OUT, 2'd2, 0, 0, 0);
    chk("R4 accept OUT", {hs_stall, rx_acc}, 2'b01);
    chk("R11 ep/kind", {r_ep, r_kind}, {2'd2, K_OUT});
    cyc(K_NONE, 2'd3, 0, 0, 0);
    chk("R12 idle quiet", {hs_stall, rx_acc}, 0);
    chk("R12 no state", {stall_req, stalled}, 0);
  endtask

  task automatic t_bulk_stall;
    cyc(K_NONE, 0, 4'b0100, 0, 0);
    chk("R2 set", stall_req, 4'b0100);
    cyc(K_OUT, 2'd2, 0, 0, 0);
    chk("R3 OUT stalled", {hs_stall, rx_acc}, 2'b10);
    chk("R9 flag set", stalled, 4'b0100);
    chk("R10 irq", irq, 4'b0100);
    cyc(K_IN, 2'd2, 0, 0, 0);
    chk("R3 persists", {hs_stall, rx_acc, stall_req}, {2'b10, 4'b0100});
    cyc(K_SETUP, 2'd2, 0, 0, 0);
    chk("R6 bulk SETUP stalled", {hs_stall, rx_acc}, 2'b10);
    chk("R6 request kept", stall_req, 4'b0100);
    cyc(K_OUT, 2'd1, 0, 0, 0);
    chk("R11 neighbour accepted", {hs_stall, rx_acc, stalled}, {2'b01, 4'b0100});
    cyc(K_NONE, 0, 0, 4'b0100, 0);
    chk("R7 clear bulk", stall_req, 0);
    cyc(K_OUT, 2'd2, 0, 0, 0);
    chk("R4 after clear", {hs_stall, rx_acc}, 2'b01);
    chk("R9 flag held", stalled, 4'b0100);
    cyc(K_NONE, 0, 0, 0, 4'b0100);
    chk("R9 ack clears", {stalled, irq}, 0);
  endtask

  task automatic t_ctrl;
    cyc(K_NONE, 0, 4'b0001, 0, 0);
    cyc(K_IN, 2'd0, 0, 0, 0);
    chk("R3 ctrl IN stalled", {hs_stall, rx_acc}, 2'b10);
    cyc(K_SETUP, 2'd0, 0, 0, 0);
    chk("R5 SETUP accepted", {hs_stall, rx_acc, r_kind}, {2'b01, K_SETUP});
    chk("R5 SETUP clears", stall_req, 0);
    cyc(K_NONE, 0, 4'b0001, 0, 0);
    cyc(K_NONE, 0, 0, 4'b0001, 0);
    chk("R7 clear ctrl", stall_req, 0);
    cyc(K_NONE, 0, 0, 0, 4'b0001);
  endtask

  task automatic t_priority;
    cyc(K_NONE, 0, 4'b0010, 4'b0010, 0);
    chk("R8 set beats clear", stall_req, 4'b0010);
    cyc(K_NONE, 0, 4'b0001, 0, 0);
    cyc(K_SETUP, 2'd0, 4'b0001, 0, 0);
    chk("R8 set beats SETUP clear", stall_req, 4'b0011);
    chk("R5 SETUP still accepted", {hs_stall, rx_acc}, 2'b01);
    f_ien = 4'b0111;
    cyc(K_NONE, 0, 4'b1000, 0, 0);
    cyc(K_OUT, 2'd3, 0, 0, 4'b1000);
    chk("R9 stall beats ack", stalled[3], 1);
    chk("R10 masked irq", irq[3], 0);
    f_ien = 4'b1111;
    #1;
    chk("R10 enabled irq", irq[3], 1);
  endtask

  initial begin
    rst_n = 1'b0; tok_kind = K_NONE; tok_ep = '0; is_ctrl = 4'b0001;
    s_set = '0; s_clr = '0; f_ack = '0; f_ien = 4'b1111;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_normal;
    t_bulk_stall;
    t_ctrl;
    t_priority;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule